// File: doc/BRIEF.md
# Hart Sleep and Wake Controller

This block puts a processor hart to sleep and wakes it again. It also lets a hart wake its neighbours. Software reaches it in two ways. The first is a pair of control registers: a machine-level register and a user-level alias. The second is two hint instructions that decode as plain no-ops on any other core. A third instruction, the standard wait-for-interrupt, shares the same sleep machinery.

A block request puts the hart to sleep until an interrupt arrives or another hart sends an unblock pulse. The request falls through at once if an unblock pulse came in since the last block request was consumed. The request also falls through if an interrupt is already pending. This gives lock-free producer/consumer code a sleep that cannot miss a wake-up.

An optional deep mode drops the clock request while the hart sleeps. On wake, the hart keeps stalling until the clock acknowledge returns. The pipeline freezes the hart on the stall output and forwards the register and instruction traffic to this block.

Top module: `hart_sleep_ctl`

## Requirements
- R1: After reset, stall is 0, clock request is 1, unblock-out is 0, and the machine register (address 0xbf0) reads 0.
- R2: The machine register reads deep-mode in bit 2, the blocked state in bit 1, and 0 in bit 0 and bits 31:3. Deep-mode is read/write and resets to 0.
- R3: The user alias (address 0xbf0 is machine, 0x8f0 is the alias) reads only bits 1:0. A write to it never changes deep-mode, and bit 2 reads back as 0.
- R4: Access to 0xbf0 below machine level is flagged illegal. Access to 0x8f0 below machine level with TW=1 is flagged illegal. An illegal access has no effect and reads 0.
- R5: The block hint (0x00002033), the unblock hint (0x00102033) and WFI (0x10500073) are flagged illegal below machine level when TW=1. They then have no effect.
- R6: Writing 1 to bit 0 of either register, or executing the unblock hint, raises unblock-out for exactly the one cycle after the request.
- R7: A block request, made by writing 1 to bit 1 or by the block hint, raises stall from the next cycle. An unblock pulse or an interrupt ends the sleep, and stall drops in the cycle after the wake input is sampled.
- R8: An unblock pulse that arrives while running, or in the same cycle as the block request, makes the block request fall through without stalling. The request consumes the pulse, so the next block request sleeps.
- R9: An unblock pulse that ends a blocked sleep is consumed and is not remembered.
- R10: WFI sleeps until an interrupt only. An unblock pulse during WFI does not wake the hart, but it is remembered for the next block request.
- R11: With deep-mode set, clock request is 0 while asleep. On wake, clock request returns to 1, and stall stays high until clock acknowledge is sampled high. Stall drops the cycle after that.
- R12: Bit 1 of the machine register reads 1 during a blocked sleep and 0 once the hart is running again.
- R13: A block or WFI request made while an interrupt is pending falls through without stalling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csrEn | input | 1 | Register access valid this cycle |
| csrWr | input | 1 | Access is a write |
| csrAddr | input | 12 | Register address |
| csrWdata | input | 32 | Write data |
| csrRdata | output | 32 | Read data (combinational) |
| csrIllegal | output | 1 | Access must trap |
| privM | input | 1 | Hart is at machine level |
| twBit | input | 1 | Timeout-wait bit of machine status |
| instrValid | input | 1 | Instruction word valid this cycle |
| instrWord | input | 32 | Decoded instruction word |
| instrIllegal | output | 1 | Instruction must trap |
| irqPending | input | 1 | An enabled interrupt is pending |
| unblockIn | input | 1 | Unblock pulse from other harts |
| unblockOut | output | 1 | Unblock pulse to other harts |
| clkReq | output | 1 | Clock request |
| clkAck | input | 1 | Clock acknowledge |
| stall | output | 1 | Hart is asleep or waking |

## Verification
Read data and both illegal flags are combinational. The bench checks them one nanosecond after it drives inputs, before the capturing edge. Unblock-out, stall and clock request each change one edge after the request or wake input that causes them. Each driving task therefore returns on the falling edge that follows that capturing edge, and the check samples there. Deep wake-up takes one edge to leave sleep and one more edge after acknowledge is seen. The bench holds acknowledge low for an extra cycle first, to show stall does not drop early.

// File: rtl/hart_sleep_pkg.sv
package hart_sleep_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WAKE  = 2'd2
  } sleepState_e;

  // requests decoded by the datapath
  typedef struct packed {
    logic blockReq;
    logic wfiReq;
    logic unblockReq;
  } sleepReqs_t;

  // strobes driven by control into the datapath
  typedef struct packed {
    logic consumeBlock;
    logic eatUnblock;
    logic blocked;
  } ctlStrobes_t;

  localparam logic [31:0] HINT_BLOCK   = 32'h0000_2033;
  localparam logic [31:0] HINT_UNBLOCK = 32'h0010_2033;
  localparam logic [31:0] INSN_WFI     = 32'h1050_0073;

  localparam int BIT_UNBLK = 0;
  localparam int BIT_BLOCK = 1;
  localparam int BIT_DEEP  = 2;

endpackage

// File: rtl/hart_sleep_dp.sv
module hart_sleep_dp
  import hart_sleep_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] MSLEEP_ADDR = 12'hbf0,
  parameter logic [ADDR_W-1:0] USLEEP_ADDR = 12'h8f0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csrEn,
  input  logic              csrWr,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [XLEN-1:0]   csrWdata,
  output logic [XLEN-1:0]   csrRdata,
  output logic              csrIllegal,
  input  logic              privM,
  input  logic              twBit,
  input  logic              instrValid,
  input  logic [31:0]       instrWord,
  output logic              instrIllegal,
  input  logic              unblockIn,
  input  ctlStrobes_t       strobes,
  output sleepReqs_t        reqs,
  output logic              pendFlag,
  output logic              deepBit,
  output logic              unblockOut
);

  logic hitM, hitU, badM, badU, csrOk, wrOk;
  logic isBlk, isUnb, isWfi, hintTrap, instrOk;
  logic unusedWdata;

  assign unusedWdata = ^csrWdata[XLEN-1:BIT_DEEP+1];

  assign hitM = csrEn && (csrAddr == MSLEEP_ADDR);
  assign hitU = csrEn && (csrAddr == USLEEP_ADDR);
  assign badM = hitM && !privM;
  assign badU = hitU && !privM && twBit;
  assign csrIllegal = badM || badU;
  assign csrOk = (hitM && !badM) || (hitU && !badU);
  assign wrOk = csrOk && csrWr;

  assign isBlk = instrWord == HINT_BLOCK;
  assign isUnb = instrWord == HINT_UNBLOCK;
  assign isWfi = instrWord == INSN_WFI;
  assign hintTrap = instrValid && (isBlk || isUnb || isWfi) && !privM && twBit;
  assign instrIllegal = hintTrap;
  assign instrOk = instrValid && !hintTrap;

  assign reqs.blockReq   = (wrOk && csrWdata[BIT_BLOCK]) || (instrOk && isBlk);
  assign reqs.unblockReq = (wrOk && csrWdata[BIT_UNBLK]) || (instrOk && isUnb);
  assign reqs.wfiReq     = instrOk && isWfi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      deepBit <= 1'b0;
      pendFlag <= 1'b0;
      unblockOut <= 1'b0;
    end else begin
      if (wrOk && hitM) deepBit <= csrWdata[BIT_DEEP];
      unblockOut <= reqs.unblockReq;
      if (strobes.consumeBlock) pendFlag <= 1'b0;
      else if (unblockIn && !strobes.eatUnblock) pendFlag <= 1'b1;
    end
  end

  always_comb begin
    csrRdata = '0;
    if (csrOk) begin
      csrRdata[BIT_BLOCK] = strobes.blocked;
      if (hitM) csrRdata[BIT_DEEP] = deepBit;
    end
  end

endmodule

// File: rtl/hart_sleep_ctrl.sv
module hart_sleep_ctrl
  import hart_sleep_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  sleepReqs_t  reqs,
  input  logic        pendFlag,
  input  logic        deepBit,
  input  logic        unblockIn,
  input  logic        irqPending,
  input  logic        clkAck,
  output ctlStrobes_t strobes,
  output logic        stall,
  output logic        clkReq
);

  sleepState_e state, stateNext;
  logic blockMode, deepMode;
  logic pendEff, wakeNow;

  assign pendEff = pendFlag || unblockIn;
  assign wakeNow = irqPending || (blockMode && unblockIn);

  always_comb begin
    stateNext = state;
    strobes = '0;
    strobes.blocked = blockMode && (state != ST_RUN);
    case (state)
      ST_RUN: begin
        if (reqs.blockReq) begin
          strobes.consumeBlock = 1'b1;
          if (!pendEff && !irqPending) stateNext = ST_SLEEP;
        end else if (reqs.wfiReq) begin
          if (!irqPending) stateNext = ST_SLEEP;
        end
      end
      ST_SLEEP: begin
        strobes.eatUnblock = blockMode && unblockIn;
        if (wakeNow) stateNext = deepMode ? ST_WAKE : ST_RUN;
      end
      ST_WAKE: begin
        if (clkAck) stateNext = ST_RUN;
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_RUN;
      blockMode <= 1'b0;
      deepMode <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_RUN && stateNext == ST_SLEEP) begin
        blockMode <= reqs.blockReq;
        deepMode <= deepBit;
      end else if (stateNext == ST_RUN) begin
        blockMode <= 1'b0;
      end
    end
  end

  assign stall = state != ST_RUN;
  assign clkReq = !(state == ST_SLEEP && deepMode);

endmodule

// File: rtl/hart_sleep_ctl.sv
module hart_sleep_ctl
  import hart_sleep_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] MSLEEP_ADDR = 12'hbf0,
  parameter logic [ADDR_W-1:0] USLEEP_ADDR = 12'h8f0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csrEn,
  input  logic              csrWr,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [XLEN-1:0]   csrWdata,
  output logic [XLEN-1:0]   csrRdata,
  output logic              csrIllegal,
  input  logic              privM,
  input  logic              twBit,
  input  logic              instrValid,
  input  logic [31:0]       instrWord,
  output logic              instrIllegal,
  input  logic              irqPending,
  input  logic              unblockIn,
  output logic              unblockOut,
  output logic              clkReq,
  input  logic              clkAck,
  output logic              stall
);

  sleepReqs_t  reqs;
  ctlStrobes_t strobes;
  logic pendFlag, deepBit;

  hart_sleep_dp #(
    .XLEN(XLEN), .ADDR_W(ADDR_W),
    .MSLEEP_ADDR(MSLEEP_ADDR), .USLEEP_ADDR(USLEEP_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .csrEn(csrEn), .csrWr(csrWr), .csrAddr(csrAddr), .csrWdata(csrWdata),
    .csrRdata(csrRdata), .csrIllegal(csrIllegal),
    .privM(privM), .twBit(twBit),
    .instrValid(instrValid), .instrWord(instrWord), .instrIllegal(instrIllegal),
    .unblockIn(unblockIn), .strobes(strobes), .reqs(reqs),
    .pendFlag(pendFlag), .deepBit(deepBit), .unblockOut(unblockOut)
  );

  hart_sleep_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqs(reqs), .pendFlag(pendFlag), .deepBit(deepBit),
    .unblockIn(unblockIn), .irqPending(irqPending), .clkAck(clkAck),
    .strobes(strobes), .stall(stall), .clkReq(clkReq)
  );

endmodule

// File: rtl/hart_sleep_chk.sv
module hart_sleep_chk #(
  parameter int XLEN = 32,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] MSLEEP_ADDR = 12'hbf0
) (
  input logic              clk,
  input logic              rstN,
  input logic              csrEn,
  input logic [ADDR_W-1:0] csrAddr,
  input logic [XLEN-1:0]   csrRdata,
  input logic              privM,
  input logic              instrValid,
  input logic              instrIllegal,
  input logic              unblockOut,
  input logic              clkReq,
  input logic              stall
);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    csrRdata[XLEN-1:3] == '0);

  assert_illegal_silent_R5: assert property (@(posedge clk) disable iff (!rstN)
    (instrIllegal && !csrEn) |=> !unblockOut);

  assert_pulse_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    unblockOut |-> $past(csrEn || instrValid));

  assert_sleep_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stall) |-> $past(csrEn || instrValid));

  assert_clkreq_only_asleep_R11: assert property (@(posedge clk) disable iff (!rstN)
    !clkReq |-> stall);

  assert_wake_waits_ack_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkReq) |-> stall);

  assert_blocked_readback_R12: assert property (@(posedge clk) disable iff (!rstN)
    (csrEn && csrAddr == MSLEEP_ADDR && privM && !stall) |-> !csrRdata[1]);

endmodule

bind hart_sleep_ctl hart_sleep_chk #(
  .XLEN(XLEN), .ADDR_W(ADDR_W), .MSLEEP_ADDR(MSLEEP_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .csrEn(csrEn), .csrAddr(csrAddr), .csrRdata(csrRdata),
  .privM(privM), .instrValid(instrValid), .instrIllegal(instrIllegal),
  .unblockOut(unblockOut), .clkReq(clkReq), .stall(stall)
);

// File: tb/hart_sleep_ctl_tb.sv
module hart_sleep_ctl_tb;

  localparam logic [31:0] BLK = 32'h0000_2033;
  localparam logic [31:0] UNB = 32'h0010_2033;
  localparam logic [31:0] WFI = 32'h1050_0073;
  localparam logic [11:0] MA = 12'hbf0;
  localparam logic [11:0] UA = 12'h8f0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csrEn = 1'b0, csrWr = 1'b0;
  logic [11:0] csrAddr = '0;
  logic [31:0] csrWdata = '0;
  logic [31:0] csrRdata;
  logic csrIllegal, instrIllegal, unblockOut, clkReq, stall;
  logic privM = 1'b1, twBit = 1'b0;
  logic instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic irqPending = 1'b0, unblockIn = 1'b0, clkAck = 1'b1;
  logic lastIll;
  int nChecks = 0;
  int nErr = 0;

  always #2 clk = ~clk;

  hart_sleep_ctl u_dut (
    .clk(clk), .rstN(rstN), .csrEn(csrEn), .csrWr(csrWr), .csrAddr(csrAddr),
    .csrWdata(csrWdata), .csrRdata(csrRdata), .csrIllegal(csrIllegal),
    .privM(privM), .twBit(twBit), .instrValid(instrValid), .instrWord(instrWord),
    .instrIllegal(instrIllegal), .irqPending(irqPending), .unblockIn(unblockIn),
    .unblockOut(unblockOut), .clkReq(clkReq), .clkAck(clkAck), .stall(stall)
  );

  typedef struct packed {
    logic pm;
    logic tw;
    logic [11:0] addr;
    logic wr;
    logic [31:0] wd;
    logic expIll;
    logic [31:0] expRd;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, MA, 1'b1, 32'h4,        1'b0, 32'h0},  // R1 reset read, set deep
    '{1'b1, 1'b0, MA, 1'b0, 32'h0,        1'b0, 32'h4},  // R2
    '{1'b0, 1'b0, UA, 1'b0, 32'h0,        1'b0, 32'h0},  // R3 alias hides deep
    '{1'b0, 1'b0, UA, 1'b1, 32'h0,        1'b0, 32'h0},  // R3 alias write
    '{1'b1, 1'b0, MA, 1'b0, 32'h0,        1'b0, 32'h4},  // R3 deep kept
    '{1'b0, 1'b0, MA, 1'b0, 32'h0,        1'b1, 32'h0},  // R4
    '{1'b0, 1'b0, MA, 1'b1, 32'h0,        1'b1, 32'h0},  // R4 illegal write
    '{1'b1, 1'b0, MA, 1'b0, 32'h0,        1'b0, 32'h4},  // R4 no effect
    '{1'b0, 1'b1, UA, 1'b0, 32'h0,        1'b1, 32'h0},  // R4 TW trap
    '{1'b1, 1'b1, MA, 1'b1, 32'h0,        1'b0, 32'h4},  // R2 clear deep
    '{1'b1, 1'b0, MA, 1'b0, 32'h0,        1'b0, 32'h0},  // R2
    '{1'b1, 1'b0, MA, 1'b1, 32'hFFFF_FFF8, 1'b0, 32'h0}, // R2 reserved write
    '{1'b1, 1'b0, MA, 1'b0, 32'h0,        1'b0, 32'h0}   // R2 reserved reads 0
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finishUp();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  endtask

  task automatic hint(input logic pm, input logic tw, input logic [31:0] w);
    @(negedge clk);
    privM = pm; twBit = tw; instrValid = 1'b1; instrWord = w;
    #1 lastIll = instrIllegal;
    @(negedge clk);
    instrValid = 1'b0; privM = 1'b1; twBit = 1'b0;
  endtask

  task automatic csrW(input logic pm, input logic tw, input logic [11:0] a,
                      input logic [31:0] d);
    @(negedge clk);
    privM = pm; twBit = tw; csrEn = 1'b1; csrWr = 1'b1; csrAddr = a; csrWdata = d;
    #1 lastIll = csrIllegal;
    @(negedge clk);
    csrEn = 1'b0; csrWr = 1'b0; privM = 1'b1; twBit = 1'b0;
  endtask

  task automatic pulseUnb();
    @(negedge clk); unblockIn = 1'b1;
    @(negedge clk); unblockIn = 1'b0;
  endtask

  task automatic pulseIrq();
    @(negedge clk); irqPending = 1'b1;
    @(negedge clk); irqPending = 1'b0;
  endtask

  task automatic readM(output logic [31:0] v);
    csrEn = 1'b1; csrWr = 1'b0; csrAddr = MA; privM = 1'b1;
    #1 v = csrRdata;
    csrEn = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual hung expected done");
    finishUp();
  end

  initial begin
    logic [31:0] rv;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "stall", {31'b0, stall}, 32'h0);
    chk("R1", "clkReq", {31'b0, clkReq}, 32'h1);
    chk("R1", "unblockOut", {31'b0, unblockOut}, 32'h0);

    // table walk: register access and privilege
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      privM = VECS[i].pm; twBit = VECS[i].tw; csrEn = 1'b1;
      csrAddr = VECS[i].addr; csrWr = VECS[i].wr; csrWdata = VECS[i].wd;
      #1;
      chk("R2-table", "illegal", {31'b0, csrIllegal}, {31'b0, VECS[i].expIll});
      chk("R2-table", "rdata", csrRdata, VECS[i].expRd);
    end
    @(negedge clk);
    csrEn = 1'b0; csrWr = 1'b0; privM = 1'b1; twBit = 1'b0;

    // R6 unblock pulse via register, alias and hint
    csrW(1'b1, 1'b0, MA, 32'h1);
    chk("R6", "unblockOut after write", {31'b0, unblockOut}, 32'h1);
    @(negedge clk);
    chk("R6", "unblockOut one cycle", {31'b0, unblockOut}, 32'h0);
    csrW(1'b0, 1'b0, UA, 32'h1);
    chk("R6", "unblockOut alias", {31'b0, unblockOut}, 32'h1);
    hint(1'b1, 1'b0, UNB);
    chk("R6", "unblockOut hint", {31'b0, unblockOut}, 32'h1);

    // R5 trapped hints have no effect
    hint(1'b0, 1'b1, UNB);
    chk("R5", "unblock illegal", {31'b0, lastIll}, 32'h1);
    chk("R5", "no pulse", {31'b0, unblockOut}, 32'h0);
    hint(1'b0, 1'b1, BLK);
    chk("R5", "block illegal", {31'b0, lastIll}, 32'h1);
    chk("R5", "no sleep", {31'b0, stall}, 32'h0);
    hint(1'b0, 1'b1, WFI);
    chk("R5", "wfi illegal", {31'b0, lastIll}, 32'h1);
    chk("R5", "wfi no sleep", {31'b0, stall}, 32'h0);

    // R7 / R12 blocked sleep woken by unblock
    hint(1'b1, 1'b0, BLK);
    chk("R7", "stall after block", {31'b0, stall}, 32'h1);
    readM(rv);
    chk("R12", "block bit asleep", rv, 32'h2);
    repeat (3) @(negedge clk);
    chk("R7", "still asleep", {31'b0, stall}, 32'h1);
    pulseUnb();
    chk("R7", "woken by unblock", {31'b0, stall}, 32'h0);
    readM(rv);
    chk("R12", "block bit cleared", rv, 32'h0);

    // R9 wake pulse consumed; R7 irq wake
    hint(1'b1, 1'b0, BLK);
    chk("R9", "sleeps again", {31'b0, stall}, 32'h1);
    pulseIrq();
    chk("R7", "woken by irq", {31'b0, stall}, 32'h0);

    // R8 fall-through on earlier pulse
    pulseUnb();
    hint(1'b1, 1'b0, BLK);
    chk("R8", "falls through", {31'b0, stall}, 32'h0);
    csrW(1'b1, 1'b0, MA, 32'h2);
    chk("R8", "pulse consumed", {31'b0, stall}, 32'h1);
    pulseIrq();
    // same-cycle pulse
    @(negedge clk);
    instrValid = 1'b1; instrWord = BLK; unblockIn = 1'b1;
    @(negedge clk);
    instrValid = 1'b0; unblockIn = 1'b0;
    chk("R8", "same-cycle falls through", {31'b0, stall}, 32'h0);
    hint(1'b1, 1'b0, BLK);
    chk("R8", "same-cycle consumed", {31'b0, stall}, 32'h1);
    pulseIrq();

    // R13 pending interrupt
    @(negedge clk); irqPending = 1'b1;
    hint(1'b1, 1'b0, BLK);
    chk("R13", "block with irq", {31'b0, stall}, 32'h0);
    hint(1'b1, 1'b0, WFI);
    chk("R13", "wfi with irq", {31'b0, stall}, 32'h0);
    irqPending = 1'b0;

    // R10 WFI ignores unblock but remembers it
    hint(1'b1, 1'b0, WFI);
    chk("R10", "wfi sleeps", {31'b0, stall}, 32'h1);
    pulseUnb();
    chk("R10", "unblock no wake", {31'b0, stall}, 32'h1);
    pulseIrq();
    chk("R10", "irq wakes", {31'b0, stall}, 32'h0);
    hint(1'b1, 1'b0, BLK);
    chk("R10", "remembered pulse", {31'b0, stall}, 32'h0);

    // R11 deep sleep handshake
    csrW(1'b1, 1'b0, MA, 32'h4);
    hint(1'b1, 1'b0, BLK);
    chk("R11", "stall deep", {31'b0, stall}, 32'h1);
    chk("R11", "clkReq low", {31'b0, clkReq}, 32'h0);
    clkAck = 1'b0;
    pulseIrq();
    chk("R11", "clkReq back", {31'b0, clkReq}, 32'h1);
    chk("R11", "stall waits ack", {31'b0, stall}, 32'h1);
    @(negedge clk);
    chk("R11", "still waiting", {31'b0, stall}, 32'h1);
    clkAck = 1'b1;
    @(negedge clk);
    chk("R11", "stall drops", {31'b0, stall}, 32'h0);

    finishUp();
  end

endmodule